// File: doc/BRIEF.md
# SD Command Sequencer Context Engine

This block stores a small set of command descriptors for a memory-card host controller and replays a chosen run of them without software help between commands. Each descriptor (a "context") carries seven 64-bit fields: command word, argument, block size, sector count, expected response, response-check mask and DMA address. The contexts are split into tables of equal size. Software picks a table and a slot, then writes fields by offset. A write to the launch register with its go bit set names a table, a first slot and a last slot. The engine then presents each context in turn on a command-issue handshake and waits for a completion report before it moves on.

The card bus, data movement and CRC sit outside the block. The block sees them only as a ready signal on the issue side and a completion pulse that carries an error flag. When a run ends cleanly, a done status bit is set. A command that reports an error stops the run and sets an error status bit. Each status bit can raise the interrupt through a mask. A launch written while a run is active is held in a single pending slot and starts as soon as the active run ends. This lets a long job span both tables with two back-to-back launches.

States: IDLE (nothing active), ISSUE (context presented, waiting for ready), WAIT (command accepted, waiting for completion). Transitions: IDLE to ISSUE on launch; ISSUE to WAIT on ready; WAIT to ISSUE on clean completion with more slots, or with a pending launch at the last slot; WAIT to IDLE on clean completion of the last slot with nothing pending, or on an error; any state to IDLE on a sequencer reset.

Top module: `sdseq_engine`

## Requirements
- R1: After reset the issue valid is low, both status bits are 0, both mask bits are 1 (masked) and the interrupt is low.
- R2: A write to offset 0x00 selects a slot from bits [1:0] and a table from bit 8. A write to offset 0x40+8*k (k = 0 command, 1 argument, 2 size, 3 sector count, 4 response, 5 response-check, 6 address) stores the data in field k of that context. The issue port shows exactly these stored values.
- R3: A write to offset 0x10 with bit 0 set starts a run. Start slot is bits [13:12], last slot is bits [9:8] and table is bit 28. Contexts are presented in slot order. Issue valid stays high until ready is seen.
- R4: After a context is accepted, issue valid stays low until a completion is reported.
- R5: The slot number steps up modulo the table size. A last slot below the start slot wraps around, and equal slots issue one command.
- R6: Bit 16 of the launch word is driven on iss_sd for every command of that run.
- R7: A write to offset 0x10 with bit 0 clear starts nothing.
- R8: A launch written while a run is active is held and starts right after the active run's last completion. A newer held launch replaces an older one.
- R9: Status bit 0 (offset 0x20) is set when a run ends with no launch held. The interrupt is high while a status bit is set and its mask bit (offset 0x28) is clear.
- R10: A completion with the error flag stops the run, sets status bit 1 and discards any held launch.
- R11: A write to offset 0x20 clears the status bits written as 0 and keeps those written as 1.
- R12: A write to offset 0x18 with bit 0 set aborts the run and discards the held launch, leaving the status unchanged. Bits 8 and 9 of that write appear for one cycle on dma_rst[0] and dma_rst[1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | DW | Register write data |
| iss_valid | output | 1 | A context is presented for issue |
| iss_ready | input | 1 | Command path accepts the presented context |
| iss_sd | output | 1 | SD-type flag of the active run |
| iss_cmd | output | DW | Command word field |
| iss_arg | output | DW | Argument field |
| iss_size | output | DW | Block size field |
| iss_seccnt | output | DW | Sector count field |
| iss_rsp | output | DW | Expected response field |
| iss_rspchk | output | DW | Response-check mask field |
| iss_addr | output | DW | DMA address field |
| cmp_valid | input | 1 | Completion of the accepted command |
| cmp_err | input | 1 | The completed command failed |
| seq_done | output | 1 | Status bit 0 |
| seq_err | output | 1 | Status bit 1 |
| irq | output | 1 | Unmasked status interrupt |
| dma_rst | output | 2 | One-cycle DMA channel reset pulses |

## Verification
The bench builds the block with its defaults: four slots per table, two tables, 64-bit fields and 8-bit offsets. With these values it can fill all eight contexts with distinct data and chain a run across both tables. The two-bit slot counter lets it wrap from slot 3 back to slot 0. A behavioural model steps alongside on every clock, while a responder varies ready throttling and completion delay. Error and abort land while a launch is held, so the discard paths are exercised.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    localparam int NUM_FIELDS = 7;
    localparam int FLD_CMD    = 0;
    localparam int FLD_ARG    = 1;
    localparam int FLD_SIZE   = 2;
    localparam int FLD_SECCNT = 3;
    localparam int FLD_RSP    = 4;
    localparam int FLD_RSPCHK = 5;
    localparam int FLD_ADDR   = 6;

    localparam logic [7:0] OFS_SEL  = 8'h00;
    localparam logic [7:0] OFS_CTRL = 8'h10;
    localparam logic [7:0] OFS_RST  = 8'h18;
    localparam logic [7:0] OFS_STAT = 8'h20;
    localparam logic [7:0] OFS_MASK = 8'h28;
    localparam logic [7:0] OFS_FLD  = 8'h40;

    localparam int SEL_TAB_LSB    = 8;
    localparam int CTRL_GO        = 0;
    localparam int CTRL_LAST_LSB  = 8;
    localparam int CTRL_FIRST_LSB = 12;
    localparam int CTRL_SD        = 16;
    localparam int CTRL_TAB_LSB   = 28;
    localparam int RST_SEQ        = 0;
    localparam int RST_DMA_LSB    = 8;

endpackage

// File: rtl/sdseq_ctx_store.sv
module sdseq_ctx_store
    import sdseq_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int TABLES = 2,
    parameter int DW     = 64,
    parameter int AW     = 8,
    localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int TW    = (TABLES > 1) ? $clog2(TABLES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [AW-1:0]                     addr,
    input  logic [DW-1:0]                     wdata,
    input  logic [TW-1:0]                     rd_tab,
    input  logic [SW-1:0]                     rd_slot,
    output logic [NUM_FIELDS-1:0][DW-1:0]     rd_ctx
);
    localparam int NCTX = SLOTS * TABLES;
    localparam int FW   = $clog2(NUM_FIELDS);
    localparam int CW   = SW + TW;

    logic [SW-1:0]  sel_slot_q;
    logic [TW-1:0]  sel_tab_q;
    logic [AW-1:0]  fld_off;
    logic           fld_hit;
    logic [FW-1:0]  fld_idx;
    logic [CW-1:0]  sel_idx;
    logic [CW-1:0]  rd_idx;
    logic [NUM_FIELDS-1:0][DW-1:0] rows [NCTX];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_slot_q <= '0;
            sel_tab_q  <= '0;
        end else if (wr_en && addr == AW'(OFS_SEL)) begin
            sel_slot_q <= wdata[SW-1:0];
            sel_tab_q  <= wdata[SEL_TAB_LSB +: TW];
        end
    end

    always_comb begin
        fld_off = addr - AW'(OFS_FLD);
        fld_idx = fld_off[3 +: FW];
        fld_hit = wr_en && (addr >= AW'(OFS_FLD)) && (fld_off[2:0] == 3'd0)
                  && (int'(fld_off[AW-1:3]) < NUM_FIELDS);
        sel_idx = {sel_tab_q, sel_slot_q};
        rd_idx  = {rd_tab, rd_slot};
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        logic [NUM_FIELDS-1:0][DW-1:0] row_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q <= '0;
            end else if (fld_hit && sel_idx == CW'(c)) begin
                row_q[fld_idx] <= wdata;
            end
        end
        assign rows[c] = row_q;
    end

    assign rd_ctx = rows[rd_idx];

endmodule

// File: rtl/sdseq_regs.sv
module sdseq_regs
    import sdseq_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    wd_low,
    input  logic [1:0]    wd_dma,
    input  logic          set_done,
    input  logic          set_err,
    output logic          launch_go,
    output logic          seq_abort,
    output logic [1:0]    status,
    output logic          irq,
    output logic [1:0]    dma_rst
);
    logic [1:0] status_q, mask_q, dma_q;
    logic       wr_stat, wr_rst;

    always_comb begin
        wr_stat   = wr_en && addr == AW'(OFS_STAT);
        wr_rst    = wr_en && addr == AW'(OFS_RST);
        launch_go = wr_en && addr == AW'(OFS_CTRL) && wd_low[CTRL_GO];
        seq_abort = wr_rst && wd_low[RST_SEQ];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 2'b00;
            mask_q   <= 2'b11;
            dma_q    <= 2'b00;
        end else begin
            status_q <= (wr_stat ? (status_q & wd_low) : status_q) | {set_err, set_done};
            if (wr_en && addr == AW'(OFS_MASK)) begin
                mask_q <= wd_low;
            end
            dma_q <= wr_rst ? wd_dma : 2'b00;
        end
    end

    assign status  = status_q;
    assign irq     = |(status_q & ~mask_q);
    assign dma_rst = dma_q;

endmodule

// File: rtl/sdseq_fsm.sv
module sdseq_fsm
    import sdseq_pkg::*;
#(
    parameter int SW = 2,
    parameter int TW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_go,
    input  logic [SW-1:0] l_first,
    input  logic [SW-1:0] l_last,
    input  logic [TW-1:0] l_tab,
    input  logic          l_sd,
    input  logic          abort,
    input  logic          iss_ready,
    input  logic          cmp_valid,
    input  logic          cmp_err,
    output logic          iss_valid,
    output logic          waiting,
    output logic [TW-1:0] cur_tab,
    output logic [SW-1:0] cur_slot,
    output logic          cur_sd,
    output logic          set_done,
    output logic          set_err
);
    typedef struct packed {
        logic          vld;
        logic          sd;
        logic [TW-1:0] tab;
        logic [SW-1:0] first;
        logic [SW-1:0] last;
    } run_t;

    seq_state_e    state_q, state_d;
    logic [SW-1:0] slot_q, slot_d, last_q, last_d;
    logic [TW-1:0] tab_q, tab_d;
    logic          sd_q, sd_d;
    run_t          pend_q, pend_d, req;

    always_comb begin
        req       = '{vld: 1'b1, sd: l_sd, tab: l_tab, first: l_first, last: l_last};
        state_d   = state_q;
        slot_d    = slot_q;
        last_d    = last_q;
        tab_d     = tab_q;
        sd_d      = sd_q;
        pend_d    = pend_q;
        set_done  = 1'b0;
        set_err   = 1'b0;
        if (launch_go && state_q != ST_IDLE) begin
            pend_d = req;
        end
        unique case (state_q)
            ST_IDLE: begin
                if (launch_go) begin
                    state_d = ST_ISSUE;
                    slot_d  = req.first;
                    last_d  = req.last;
                    tab_d   = req.tab;
                    sd_d    = req.sd;
                end
            end
            ST_ISSUE: begin
                if (iss_ready) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (cmp_valid) begin
                    if (cmp_err) begin
                        set_err    = 1'b1;
                        pend_d.vld = 1'b0;
                        state_d    = ST_IDLE;
                    end else if (slot_q == last_q) begin
                        if (pend_d.vld) begin
                            state_d    = ST_ISSUE;
                            slot_d     = pend_d.first;
                            last_d     = pend_d.last;
                            tab_d      = pend_d.tab;
                            sd_d       = pend_d.sd;
                            pend_d.vld = 1'b0;
                        end else begin
                            set_done = 1'b1;
                            state_d  = ST_IDLE;
                        end
                    end else begin
                        slot_d  = slot_q + 1'b1;
                        state_d = ST_ISSUE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort) begin
            state_d    = ST_IDLE;
            pend_d.vld = 1'b0;
            set_done   = 1'b0;
            set_err    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            last_q  <= '0;
            tab_q   <= '0;
            sd_q    <= 1'b0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            last_q  <= last_d;
            tab_q   <= tab_d;
            sd_q    <= sd_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        iss_valid = (state_q == ST_ISSUE);
        waiting   = (state_q == ST_WAIT);
        cur_tab   = tab_q;
        cur_slot  = slot_q;
        cur_sd    = sd_q;
    end

endmodule

// File: rtl/sdseq_engine.sv
module sdseq_engine
    import sdseq_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int TABLES = 2,
    parameter int DW     = 64,
    parameter int AW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic          iss_valid,
    input  logic          iss_ready,
    output logic          iss_sd,
    output logic [DW-1:0] iss_cmd,
    output logic [DW-1:0] iss_arg,
    output logic [DW-1:0] iss_size,
    output logic [DW-1:0] iss_seccnt,
    output logic [DW-1:0] iss_rsp,
    output logic [DW-1:0] iss_rspchk,
    output logic [DW-1:0] iss_addr,
    input  logic          cmp_valid,
    input  logic          cmp_err,
    output logic          seq_done,
    output logic          seq_err,
    output logic          irq,
    output logic [1:0]    dma_rst
);
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int TW = (TABLES > 1) ? $clog2(TABLES) : 1;

    logic          launch_go, seq_abort, set_done, set_err, waiting;
    logic [1:0]    status;
    logic [TW-1:0] cur_tab;
    logic [SW-1:0] cur_slot;
    logic [NUM_FIELDS-1:0][DW-1:0] ctx;

    sdseq_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wd_low    (reg_wdata[1:0]),
        .wd_dma    (reg_wdata[RST_DMA_LSB +: 2]),
        .set_done  (set_done),
        .set_err   (set_err),
        .launch_go (launch_go),
        .seq_abort (seq_abort),
        .status    (status),
        .irq       (irq),
        .dma_rst   (dma_rst)
    );

    sdseq_fsm #(.SW(SW), .TW(TW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_go (launch_go),
        .l_first   (reg_wdata[CTRL_FIRST_LSB +: SW]),
        .l_last    (reg_wdata[CTRL_LAST_LSB +: SW]),
        .l_tab     (reg_wdata[CTRL_TAB_LSB +: TW]),
        .l_sd      (reg_wdata[CTRL_SD]),
        .abort     (seq_abort),
        .iss_ready (iss_ready),
        .cmp_valid (cmp_valid),
        .cmp_err   (cmp_err),
        .iss_valid (iss_valid),
        .waiting   (waiting),
        .cur_tab   (cur_tab),
        .cur_slot  (cur_slot),
        .cur_sd    (iss_sd),
        .set_done  (set_done),
        .set_err   (set_err)
    );

    sdseq_ctx_store #(.SLOTS(SLOTS), .TABLES(TABLES), .DW(DW), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rd_tab  (cur_tab),
        .rd_slot (cur_slot),
        .rd_ctx  (ctx)
    );

    assign iss_cmd    = ctx[FLD_CMD];
    assign iss_arg    = ctx[FLD_ARG];
    assign iss_size   = ctx[FLD_SIZE];
    assign iss_seccnt = ctx[FLD_SECCNT];
    assign iss_rsp    = ctx[FLD_RSP];
    assign iss_rspchk = ctx[FLD_RSPCHK];
    assign iss_addr   = ctx[FLD_ADDR];
    assign seq_done   = status[0];
    assign seq_err    = status[1];

endmodule

// File: rtl/sdseq_chk.sv
module sdseq_chk
    import sdseq_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic          wd_bit0,
    input logic [1:0]    wd_dma,
    input logic          iss_valid,
    input logic          iss_ready,
    input logic          cmp_valid,
    input logic          cmp_err,
    input logic          waiting,
    input logic          seq_done,
    input logic          seq_err,
    input logic          irq,
    input logic [1:0]    dma_rst
);
    logic rst_wr, abort_w;
    assign rst_wr  = reg_wr && reg_addr == AW'(OFS_RST);
    assign abort_w = rst_wr && wd_bit0;

    a_r4_quiet_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_ready |=> !iss_valid);

    a_r3_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && !iss_ready && !abort_w |=> iss_valid);

    a_r10_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && cmp_valid && cmp_err && !abort_w |=> seq_err && !iss_valid);

    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (seq_done || seq_err));

    a_r12_dma_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wr |=> dma_rst == wd_dma_q);

    a_r12_dma_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_wr |=> dma_rst == 2'b00);

    logic [1:0] wd_dma_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_dma_q <= 2'b00;
        else        wd_dma_q <= wd_dma;
    end

endmodule

bind sdseq_engine sdseq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .wd_bit0   (reg_wdata[0]),
    .wd_dma    (reg_wdata[9:8]),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .cmp_valid (cmp_valid),
    .cmp_err   (cmp_err),
    .waiting   (waiting),
    .seq_done  (seq_done),
    .seq_err   (seq_err),
    .irq       (irq),
    .dma_rst   (dma_rst)
);

// File: tb/sdseq_engine_bench.sv
`timescale 1ns/1ps
module sdseq_engine_bench;
    localparam int SLOTS = 4;
    localparam int TABLES = 2;
    localparam int DW = 64;
    localparam int AW = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, reg_wr, iss_ready, cmp_valid, cmp_err;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic          iss_valid, iss_sd, seq_done, seq_err, irq;
    logic [DW-1:0] iss_cmd, iss_arg, iss_size, iss_seccnt, iss_rsp, iss_rspchk, iss_addr;
    logic [1:0]    dma_rst;

    sdseq_engine #(.SLOTS(SLOTS), .TABLES(TABLES), .DW(DW), .AW(AW)) u_sdseq_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_sd(iss_sd),
        .iss_cmd(iss_cmd), .iss_arg(iss_arg), .iss_size(iss_size), .iss_seccnt(iss_seccnt),
        .iss_rsp(iss_rsp), .iss_rspchk(iss_rspchk), .iss_addr(iss_addr),
        .cmp_valid(cmp_valid), .cmp_err(cmp_err), .seq_done(seq_done), .seq_err(seq_err),
        .irq(irq), .dma_rst(dma_rst)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // behavioural model state
    int m_state, m_slot, m_last, m_tab, m_sd, m_wcnt;
    int q_v, q_first, q_last, q_tab, q_sd;
    int sel_slot, sel_tab;
    logic [1:0] m_stat, m_mask, m_dma;
    logic [63:0] mctx [8][7];
    logic [63:0] log_cmd[$];
    logic [63:0] log_arg[$];
    int exp_q[$];

    int ready_mode = 0;
    int cmp_delay = 0;
    logic err_armed = 1'b0;
    logic [63:0] err_cmd = '0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h time=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int cur_idx();
        return m_tab * SLOTS + m_slot;
    endfunction

    task automatic compare();
        chk("R3 iss_valid", {63'd0, iss_valid}, {63'd0, m_state == 1});
        if (m_state == 1) begin
            chk("R2 cmd", iss_cmd, mctx[cur_idx()][0]);
            chk("R2 arg", iss_arg, mctx[cur_idx()][1]);
            chk("R2 size", iss_size, mctx[cur_idx()][2]);
            chk("R2 seccnt", iss_seccnt, mctx[cur_idx()][3]);
            chk("R2 rsp", iss_rsp, mctx[cur_idx()][4]);
            chk("R2 rspchk", iss_rspchk, mctx[cur_idx()][5]);
            chk("R2 addr", iss_addr, mctx[cur_idx()][6]);
            chk("R6 iss_sd", {63'd0, iss_sd}, 64'(m_sd));
        end
        chk("R9 seq_done", {63'd0, seq_done}, {63'd0, m_stat[0]});
        chk("R10 seq_err", {63'd0, seq_err}, {63'd0, m_stat[1]});
        chk("R9 irq", {63'd0, irq}, {63'd0, |(m_stat & ~m_mask)});
        chk("R12 dma_rst", {62'd0, dma_rst}, {62'd0, m_dma});
    endtask

    task automatic respond();
        iss_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        cmp_valid = (m_state == 2) && (m_wcnt >= cmp_delay);
        cmp_err   = cmp_valid && err_armed && (mctx[cur_idx()][0] == err_cmd);
    endtask

    task automatic step_model();
        logic go, ab;
        logic [1:0] ns;
        int nst, nslot, nlast, ntab, nsd, nw, nqv, nqf, nql, nqt, nqs, setd, sete, fi;
        go = reg_wr && reg_addr == 8'h10 && reg_wdata[0];
        ab = reg_wr && reg_addr == 8'h18 && reg_wdata[0];
        nst = m_state; nslot = m_slot; nlast = m_last; ntab = m_tab; nsd = m_sd; nw = m_wcnt;
        nqv = q_v; nqf = q_first; nql = q_last; nqt = q_tab; nqs = q_sd;
        setd = 0; sete = 0;
        if (go && m_state != 0) begin
            nqv = 1; nqf = int'(reg_wdata[13:12]); nql = int'(reg_wdata[9:8]);
            nqt = int'(reg_wdata[28]); nqs = int'(reg_wdata[16]);
        end
        case (m_state)
            0: if (go) begin
                nst = 1; nslot = int'(reg_wdata[13:12]); nlast = int'(reg_wdata[9:8]);
                ntab = int'(reg_wdata[28]); nsd = int'(reg_wdata[16]);
            end
            1: if (iss_ready) begin
                log_cmd.push_back(mctx[cur_idx()][0]);
                log_arg.push_back(mctx[cur_idx()][1]);
                nst = 2; nw = 0;
            end
            default: begin
                nw = m_wcnt + 1;
                if (cmp_valid) begin
                    if (cmp_err) begin
                        sete = 1; nqv = 0; nst = 0;
                    end else if (m_slot == m_last) begin
                        if (nqv != 0) begin
                            nst = 1; nslot = nqf; nlast = nql; ntab = nqt; nsd = nqs; nqv = 0;
                        end else begin
                            setd = 1; nst = 0;
                        end
                    end else begin
                        nslot = (m_slot + 1) % SLOTS; nst = 1;
                    end
                end
            end
        endcase
        if (ab) begin
            nst = 0; nqv = 0; setd = 0; sete = 0;
        end
        ns = m_stat;
        if (reg_wr && reg_addr == 8'h20) ns = ns & reg_wdata[1:0];
        if (setd != 0) ns[0] = 1'b1;
        if (sete != 0) ns[1] = 1'b1;
        m_stat = ns;
        if (reg_wr && reg_addr == 8'h28) m_mask = reg_wdata[1:0];
        m_dma = (reg_wr && reg_addr == 8'h18) ? reg_wdata[9:8] : 2'b00;
        if (reg_wr && reg_addr >= 8'h40 && reg_addr < 8'h78 && reg_addr[2:0] == 3'd0) begin
            fi = int'(reg_addr - 8'h40) / 8;
            mctx[sel_tab * SLOTS + sel_slot][fi] = reg_wdata;
        end
        if (reg_wr && reg_addr == 8'h00) begin
            sel_slot = int'(reg_wdata[1:0]);
            sel_tab = int'(reg_wdata[8]);
        end
        m_state = nst; m_slot = nslot; m_last = nlast; m_tab = ntab; m_sd = nsd; m_wcnt = nw;
        q_v = nqv; q_first = nqf; q_last = nql; q_tab = nqt; q_sd = nqs;
    endtask

    task automatic tick();
        compare();
        respond();
        step_model();
        cyc++;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    function automatic logic [63:0] ctrl(input int first, input int last, input int tab, input int sd);
        return 64'd1 | (64'(last) << 8) | (64'(first) << 12) | (64'(sd) << 16) | (64'(tab) << 28);
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 400 && (m_state != 0 || q_v != 0); i++) tick();
        tick();
    endtask

    task automatic chk_log(input string req);
        chk({req, " count"}, 64'(log_cmd.size()), 64'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < log_cmd.size(); i++)
            chk({req, " order"}, log_cmd[i], mctx[exp_q[i]][0]);
        log_cmd.delete();
        log_arg.delete();
        exp_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        iss_ready = 1'b0; cmp_valid = 1'b0; cmp_err = 1'b0;
        m_state = 0; m_slot = 0; m_last = 0; m_tab = 0; m_sd = 0; m_wcnt = 0;
        q_v = 0; q_first = 0; q_last = 0; q_tab = 0; q_sd = 0;
        sel_slot = 0; sel_tab = 0; m_stat = 2'b00; m_mask = 2'b11; m_dma = 2'b00;
        for (int c = 0; c < 8; c++) for (int f = 0; f < 7; f++) mctx[c][f] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 iss_valid", {63'd0, iss_valid}, 64'd0);
        chk("R1 irq", {63'd0, irq}, 64'd0);
        chk("R1 status", {62'd0, seq_err, seq_done}, 64'd0);

        // R2: fill every context through slot select and field offsets
        for (int n = 0; n < 8; n++) begin
            wr(8'h00, (n < 4) ? 64'(n) : (64'h100 | 64'(n - 4)));
            for (int f = 0; f < 7; f++)
                wr(8'(8'h40 + 8 * f), {8'(8'hC0 + n), 8'(f), 48'h0000_1234_5678});
        end

        // R3, R9: table 0 slots 0..3, SD type
        wr(8'h10, ctrl(0, 3, 0, 1));
        wait_idle();
        exp_q = '{0, 1, 2, 3};
        chk_log("R3 table0 run");
        chk("R9 done set", {63'd0, seq_done}, 64'd1);
        chk("R9 irq masked", {63'd0, irq}, 64'd0);
        wr(8'h28, 64'h0);
        chk("R9 irq unmasked", {63'd0, irq}, 64'd1);
        wr(8'h20, 64'h0);
        chk("R11 clear all", {62'd0, seq_err, seq_done}, 64'd0);

        // R8, R3: two-table chain with throttled ready and slow completion
        ready_mode = 1; cmp_delay = 2;
        wr(8'h10, ctrl(0, 3, 0, 1) | (64'd1 << 24));
        wr(8'h10, ctrl(0, 2, 1, 1));
        wait_idle();
        exp_q = '{0, 1, 2, 3, 4, 5, 6};
        chk_log("R8 chained tables");
        chk("R9 irq after chain", {63'd0, irq}, 64'd1);

        // R8: newer held launch replaces older one
        wr(8'h10, ctrl(0, 1, 0, 0));
        wr(8'h10, ctrl(0, 0, 1, 1));
        wr(8'h10, ctrl(3, 3, 1, 0));
        wait_idle();
        exp_q = '{0, 1, 7};
        chk_log("R8 replaced launch");
        ready_mode = 0; cmp_delay = 0;

        // R5: wrap and single slot
        wr(8'h10, ctrl(3, 1, 1, 0));
        wait_idle();
        exp_q = '{7, 4, 5};
        chk_log("R5 wrap");
        wr(8'h10, ctrl(2, 2, 0, 1));
        wait_idle();
        exp_q = '{2};
        chk_log("R5 single");

        // R7: launch word without go bit
        wr(8'h10, ctrl(0, 3, 0, 1) & ~64'd1);
        repeat (12) tick();
        chk("R7 no issue", {63'd0, iss_valid}, 64'd0);
        exp_q.delete();
        chk_log("R7 nothing issued");

        // R2: overwrite one field and see it issued
        wr(8'h00, 64'h102);
        wr(8'h48, 64'hDEAD_BEEF_0000_0042);
        wr(8'h10, ctrl(2, 2, 1, 0));
        wait_idle();
        chk("R2 new arg issued", (log_arg.size() == 1) ? log_arg[0] : 64'hX, 64'hDEAD_BEEF_0000_0042);
        exp_q = '{6};
        chk_log("R2 single ctx");

        // R10: error on slot 1 with a held launch
        err_armed = 1'b1; err_cmd = mctx[1][0]; cmp_delay = 1;
        wr(8'h10, ctrl(0, 3, 0, 1));
        wr(8'h10, ctrl(0, 3, 1, 1));
        wait_idle();
        repeat (5) tick();
        exp_q = '{0, 1};
        chk_log("R10 stopped on error");
        chk("R10 err bit", {63'd0, seq_err}, 64'd1);
        err_armed = 1'b0;

        // R11: selective clear keeps bits written as 1
        chk("R11 both set before", {62'd0, seq_err, seq_done}, 64'd3);
        wr(8'h20, 64'h2);
        chk("R11 done cleared err kept", {62'd0, seq_err, seq_done}, 64'd2);
        wr(8'h20, 64'h0);

        // R12: abort with held launch and DMA reset pulses
        cmp_delay = 6;
        wr(8'h10, ctrl(0, 3, 0, 1));
        wr(8'h10, ctrl(0, 3, 1, 1));
        repeat (3) tick();
        wr(8'h18, 64'h301);
        chk("R12 dma pulse", {62'd0, dma_rst}, 64'd3);
        repeat (20) tick();
        exp_q = '{0};
        chk_log("R12 aborted run");
        chk("R12 status unchanged", {62'd0, seq_err, seq_done}, 64'd0);
        chk("R12 idle", {63'd0, iss_valid}, 64'd0);

        repeat (4) tick();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule